// File: doc/BRIEF.md
# Accumulator Datapath with Logic Operations

This block is the arithmetic heart of a small 8-bit accumulator machine. It keeps an accumulator (A) and an operand register (B), and an ALU that can add, subtract, AND, OR and complement. The control sequencer raises one strobe per operation. On the next rising clock edge the result is written into A, and the zero and carry flags are refreshed. The operands are loaded through two plain load strobes that share one data input.

Three logic operations can also be started from an instruction opcode. A small decoder watches a 4-bit opcode field while an execute strobe is high. It raises the matching logic strobe for one of three code points that the rest of the instruction set leaves unused. The decoded strobes are combined by OR with the direct strobes, so both paths behave the same.

All the pins are plain control and status. No data is exchanged as a stream, so there is no valid/ready pair and no back-pressure.

If the sequencer raises more than one operation strobe at once, one operation is chosen. The priority order is add, subtract, AND, OR, NOT. The sequencer is expected never to do this.

Top module: `acc_datapath`

## Requirements
- R1: A synchronous reset clears A, B, the carry flag and the zero flag to 0.
- R2: `ld_b` loads `din` into B on every clock edge where it is high. `ld_a` loads `din` into A only when no operation strobe is active in that cycle. A and B hold their values when nothing writes them, and a load leaves both flags unchanged.
- R3: The add strobe writes (A + B) mod 256 into A. Carry takes the carry out of bit 7.
- R4: The subtract strobe writes A + (~B) + 1, modulo 256, into A. Carry takes the carry out of that 9-bit sum, which is 1 exactly when A >= B unsigned.
- R5: The AND strobe writes the bitwise AND of A and B into A.
- R6: The OR strobe writes the bitwise OR of A and B into A.
- R7: The NOT strobe writes the bitwise complement of A into A. B has no effect on the result and stays unchanged.
- R8: Every ALU write sets zero to 1 exactly when the new A is 0. AND, OR and NOT leave carry unchanged.
- R9: While `op_exec` is high, the decoder raises exactly one output for each of its three opcodes: 4'hC raises `dec_and`, 4'hD raises `dec_or` and 4'hE raises `dec_not`. For any other code, or while `op_exec` is low, all three decoder outputs are 0. A decoded strobe performs the same operation as the matching direct strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W | Load data for A or B |
| ld_a | input | 1 | Load A from din |
| ld_b | input | 1 | Load B from din |
| ctl_add | input | 1 | Add strobe |
| ctl_sub | input | 1 | Subtract strobe |
| ctl_and | input | 1 | AND strobe |
| ctl_or | input | 1 | OR strobe |
| ctl_not | input | 1 | Complement strobe |
| op_code | input | 4 | Instruction opcode field |
| op_exec | input | 1 | Opcode is valid this cycle |
| dec_and | output | 1 | Decoded AND strobe |
| dec_or | output | 1 | Decoded OR strobe |
| dec_not | output | 1 | Decoded complement strobe |
| acc_q | output | W | Accumulator A |
| b_q | output | W | Operand register B |
| carry_q | output | 1 | Carry flag |
| zero_q | output | 1 | Zero flag |

## Verification
The hardest state to reach from the ports is a carry flag that stays set through a logic operation. The bench has to drive an add or subtract that carries, then apply AND, OR or NOT, and then confirm that carry did not move. A zero result from each operation is also rare under random data. Directed sequences therefore produce it on purpose: loading equal operands and subtracting, complementing 8'hFF, and ANDing disjoint values. Random sequences that mix both strobe paths and random opcodes cover the remaining combinations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_AND = 4'hC;
  localparam logic [OPC_W-1:0] OPC_OR  = 4'hD;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'hE;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_NOT  = 3'd5
  } alu_op_e;

  // fixed precedence when several strobes collide
  function automatic alu_op_e pick_op(input logic s_add, input logic s_sub,
                                      input logic s_and, input logic s_or,
                                      input logic s_not);
    if (s_add)      return OP_ADD;
    else if (s_sub) return OP_SUB;
    else if (s_and) return OP_AND;
    else if (s_or)  return OP_OR;
    else if (s_not) return OP_NOT;
    else            return OP_NONE;
  endfunction
endpackage

// File: rtl/acc_opdec.sv
module acc_opdec
  import acc_alu_pkg::*;
(
  input  logic [OPC_W-1:0] code,
  input  logic             exec,
  output logic             hit_and,
  output logic             hit_or,
  output logic             hit_not
);
  always_comb begin
    hit_and = 1'b0;
    hit_or  = 1'b0;
    hit_not = 1'b0;
    if (exec) begin
      unique case (code)
        OPC_AND: hit_and = 1'b1;
        OPC_OR:  hit_or  = 1'b1;
        OPC_NOT: hit_not = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         arith
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum;
  logic [W-1:0]  b_eff;
  logic          cin;

  // subtraction reuses the adder with inverted operand and carry-in
  assign b_eff = (op == OP_SUB) ? ~b : b;
  assign cin   = (op == OP_SUB);
  assign sum   = {1'b0, a} + {1'b0, b_eff} + SW'(cin);

  always_comb begin
    res   = a;
    arith = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin res = sum[W-1:0]; arith = 1'b1; end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      default: res = a;
    endcase
  end

  assign cout = sum[W];
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic         ctl_add,
  input  logic         ctl_sub,
  input  logic         ctl_and,
  input  logic         ctl_or,
  input  logic         ctl_not,
  input  logic [3:0]   op_code,
  input  logic         op_exec,
  output logic         dec_and,
  output logic         dec_or,
  output logic         dec_not,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] b_q,
  output logic         carry_q,
  output logic         zero_q
);
  alu_op_e      op_sel;
  logic [W-1:0] alu_res;
  logic         alu_cout;
  logic         alu_arith;

  acc_opdec u_dec (
    .code    (op_code),
    .exec    (op_exec),
    .hit_and (dec_and),
    .hit_or  (dec_or),
    .hit_not (dec_not)
  );

  assign op_sel = pick_op(ctl_add, ctl_sub, ctl_and | dec_and,
                          ctl_or | dec_or, ctl_not | dec_not);

  acc_alu_core #(.W(W)) u_alu (
    .op    (op_sel),
    .a     (acc_q),
    .b     (b_q),
    .res   (alu_res),
    .cout  (alu_cout),
    .arith (alu_arith)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      b_q     <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (op_sel != OP_NONE) begin
        acc_q  <= alu_res;
        zero_q <= (alu_res == '0);
        if (alu_arith) carry_q <= alu_cout;
      end else if (ld_a) begin
        acc_q <= din;
      end
      if (ld_b) b_q <= din;
    end
  end
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_a,
  input logic         ld_b,
  input logic         ctl_add,
  input logic         ctl_sub,
  input logic         ctl_and,
  input logic         ctl_or,
  input logic         ctl_not,
  input logic         op_exec,
  input logic         dec_and,
  input logic         dec_or,
  input logic         dec_not,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] b_q,
  input logic         carry_q,
  input logic         zero_q
);
  logic s_and, s_or, s_not, any_op, arith;
  assign s_and  = ctl_and | dec_and;
  assign s_or   = ctl_or  | dec_or;
  assign s_not  = ctl_not | dec_not;
  assign arith  = ctl_add | ctl_sub;
  assign any_op = arith | s_and | s_or | s_not;

  p_dec_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_and, dec_or, dec_not}));

  p_dec_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !op_exec |-> !(dec_and | dec_or | dec_not));

  p_and_r5: assert property (@(posedge clk) disable iff (rst)
    (s_and && !arith) |=> acc_q == ($past(acc_q) & $past(b_q)));

  p_not_r7: assert property (@(posedge clk) disable iff (rst)
    (s_not && !arith && !s_and && !s_or && !ld_b)
      |=> (acc_q == ~$past(acc_q)) && $stable(b_q));

  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    any_op |=> zero_q == (acc_q == '0));

  p_carry_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (any_op && !arith) |=> $stable(carry_q));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!any_op && !ld_a) |=> $stable(acc_q) && $stable(zero_q) && $stable(carry_q));
endmodule

bind acc_datapath acc_datapath_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_a(ld_a), .ld_b(ld_b),
  .ctl_add(ctl_add), .ctl_sub(ctl_sub), .ctl_and(ctl_and),
  .ctl_or(ctl_or), .ctl_not(ctl_not), .op_exec(op_exec),
  .dec_and(dec_and), .dec_or(dec_or), .dec_not(dec_not),
  .acc_q(acc_q), .b_q(b_q), .carry_q(carry_q), .zero_q(zero_q)
);

// File: tb/test_acc_datapath.sv
module test_acc_datapath;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic ld_a = 0, ld_b = 0, ctl_add = 0, ctl_sub = 0, ctl_and = 0, ctl_or = 0, ctl_not = 0;
  logic [3:0]   op_code = '0;
  logic         op_exec = 1'b0;
  logic         dec_and, dec_or, dec_not;
  logic [W-1:0] acc_q, b_q;
  logic         carry_q, zero_q;

  int total = 0;
  int bad = 0;
  logic [W-1:0] ma = '0, mb = '0;
  logic         mc = 1'b0, mz = 1'b0;

  always #10 clk = ~clk;

  acc_datapath #(.W(W)) i_acc_datapath (
    .clk(clk), .rst(rst), .din(din), .ld_a(ld_a), .ld_b(ld_b),
    .ctl_add(ctl_add), .ctl_sub(ctl_sub), .ctl_and(ctl_and),
    .ctl_or(ctl_or), .ctl_not(ctl_not), .op_code(op_code), .op_exec(op_exec),
    .dec_and(dec_and), .dec_or(dec_or), .dec_not(dec_not),
    .acc_q(acc_q), .b_q(b_q), .carry_q(carry_q), .zero_q(zero_q)
  );

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2 ld_a";   1: return "R2 ld_b";
      2: return "R3 add";    3: return "R4 sub";
      4, 7: return "R5 and"; 5, 8: return "R6 or";
      6, 9: return "R7 not"; default: return "R9 idle/other";
    endcase
  endfunction

  // model of one step, from the requirements
  task automatic model(input int k, input logic [W-1:0] d);
    logic [W:0] s;
    case (k)
      0: ma = d;
      1: mb = d;
      2: begin s = {1'b0, ma} + {1'b0, mb}; ma = s[W-1:0]; mc = s[W]; mz = (ma == 0); end
      3: begin s = {1'b0, ma} + {1'b0, ~mb} + 1; ma = s[W-1:0]; mc = s[W]; mz = (ma == 0); end
      4, 7: begin ma = ma & mb; mz = (ma == 0); end
      5, 8: begin ma = ma | mb; mz = (ma == 0); end
      6, 9: begin ma = ~ma; mz = (ma == 0); end
      default: ;
    endcase
  endtask

  task automatic check(input bit ok, input string what, input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%s exp=%s", what, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(input int k, input logic [W-1:0] d, input logic [3:0] oc);
    logic ea, eo, en;
    din = d;
    case (k)
      0: ld_a = 1;  1: ld_b = 1;  2: ctl_add = 1; 3: ctl_sub = 1;
      4: ctl_and = 1; 5: ctl_or = 1; 6: ctl_not = 1;
      7: begin op_exec = 1; op_code = 4'hC; end
      8: begin op_exec = 1; op_code = 4'hD; end
      9: begin op_exec = 1; op_code = 4'hE; end
      10: begin op_exec = 1; op_code = oc; end
      default: ;
    endcase
    #1;
    ea = op_exec && op_code == 4'hC;
    eo = op_exec && op_code == 4'hD;
    en = op_exec && op_code == 4'hE;
    check({dec_and, dec_or, dec_not} == {ea, eo, en}, "R9 decoder lines",
          $sformatf("%b", {dec_and, dec_or, dec_not}), $sformatf("%b", {ea, eo, en}));
    if (k == 10) model((ea ? 7 : eo ? 8 : en ? 9 : 11), d);
    else model(k, d);
    @(negedge clk);
    {ld_a, ld_b, ctl_add, ctl_sub, ctl_and, ctl_or, ctl_not, op_exec} = '0;
    check({acc_q, b_q, carry_q, zero_q} == {ma, mb, mc, mz}, tag_of(k),
          $sformatf("a=%h b=%h c=%b z=%b", acc_q, b_q, carry_q, zero_q),
          $sformatf("a=%h b=%h c=%b z=%b", ma, mb, mc, mz));
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check({acc_q, b_q, carry_q, zero_q} == '0, "R1 reset",
          $sformatf("%h %h %b %b", acc_q, b_q, carry_q, zero_q), "0");
    // directed corners
    step(0, 8'hC8, 0); step(1, 8'h64, 0);
    step(2, 0, 0);                        // R3 add with carry: 0x2C, c=1
    step(4, 0, 0);                        // R5/R8 AND keeps carry
    step(0, 8'h55, 0); step(1, 8'h55, 0);
    step(3, 0, 0);                        // R4 equal operands: zero, c=1
    step(0, 8'h10, 0); step(1, 8'h20, 0);
    step(3, 0, 0);                        // R4 borrow: c=0
    step(0, 8'hFF, 0); step(1, 8'h0F, 0);
    step(6, 0, 0);                        // R7 not of FF -> zero, B untouched
    step(0, 8'hF0, 0); step(4, 0, 0);     // R5 disjoint -> zero
    step(5, 0, 0);                        // R6 or
    step(0, 8'h01, 0); step(1, 8'hFF, 0);
    step(2, 0, 0);                        // R3 wrap to zero with carry
    step(9, 0, 0);                        // R7/R9 decoded not keeps carry
    step(10, 8'h77, 4'h3);                // R9 unused code: nothing happens
    step(11, 0, 0);                       // R2 hold
    // R2: ld_a ignored while an op is active
    din = 8'h99; ld_a = 1;
    step(5, 8'h99, 0);
    // random
    for (int i = 0; i < 2000; i++) begin
      step(int'($urandom_range(0, 11)), 8'($urandom), 4'($urandom));
    end
    // R1: reset in the middle of operation
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    ma = 0; mb = 0; mc = 0; mz = 0;
    check({acc_q, b_q, carry_q, zero_q} == '0, "R1 reset again",
          $sformatf("%h %h %b %b", acc_q, b_q, carry_q, zero_q), "0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule